// File: doc/BRIEF.md
# Parallel Bus Write Master for Display Controllers

This block turns a stream of host bytes into write cycles on an 8-bit, 8080-style parallel bus of the kind that display controllers expose. Each host byte comes with a flag that says whether it is pixel data or a command. The block drives chip select, the data/command line, the write strobe, the read strobe and the 8-bit data bus. The read strobe never leaves its inactive high level, because the block only writes.

Every bus timing limit is given in nanoseconds. The block converts each one to system clock cycles, rounding up, using a clock-period parameter. From those counts it fixes the setup phase, the length of the write-strobe low phase, the hold after the strobe rises, and the total cycle time. The host side is a valid/ready handshake. Ready stays low while a cycle is in progress. When the host keeps valid high, consecutive bytes go out with chip select held low between them.

Top module: `par_write_master`

## Requirements
- R1: While the synchronous active-low reset is sampled low, the next clock edge drives chip select, write strobe and read strobe high, and in_ready is high once reset is released.
- R2: The read strobe output is high in every cycle.
- R3: Every accepted byte appears on the bus exactly once and in order. At the rising edge of the write strobe, the data bus holds the byte, the data/command line holds the flag (1 = display data, 0 = command), and chip select is low.
- R4: The write strobe falls exactly S cycles after the accepting clock edge and stays low exactly L cycles. S is the ceiling of the address setup time over the clock period. L is the larger of the ceiling of the minimum low time and (data setup cycles minus S).
- R5: The data bus and the data/command line change only at an accepting edge. They are stable at least the data setup cycles before the strobe rises, and at least the data hold cycles after it. The data/command line is also stable at least S cycles before the strobe falls.
- R6: Chip select stays low for at least the chip-select hold cycles after the write strobe rises.
- R7: in_ready goes low at the accepting edge and returns high exactly T-1 cycles later. T is the largest of: the cycle-time count, S+L+hold, and L plus the minimum high time. Consecutive strobe falls are at least the cycle-time count apart, and the strobe stays high at least the minimum high time between writes.
- R8: When valid is held high across several bytes, chip select stays low from the first byte's acceptance to the end of the last byte's cycle.
- R9: Chip select is low for exactly the T cycles that follow each acceptance, and high at all other times.
- R10: Changes to in_byte and in_is_data while no transfer is being accepted have no effect on the bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Host byte is offered |
| in_ready | output | 1 | Block can take a byte at this edge |
| in_byte | input | 8 | Byte to write |
| in_is_data | input | 1 | 1 = display data, 0 = command |
| bus_sel_n | output | 1 | Chip select, active low |
| bus_dc | output | 1 | Data/command line, high = data |
| bus_wr_n | output | 1 | Write strobe, active low; the byte latches on its rising edge |
| bus_rd_n | output | 1 | Read strobe, held high |
| bus_d | output | 8 | Data bus |

## Verification
The bench sends back-to-back bursts with valid held high. A design that returned ready one cycle late, or released chip select between bytes, would show a chip-select high pulse or a cycle longer than T. While the block is busy, the bench changes the input byte and flag freely. A design that latched the inputs outside acceptance would then put a byte on the bus that the scoreboard does not expect. The bench measures every strobe edge against its acceptance edge, so an off-by-one in the setup or low-phase count, or a data change inside the hold window, fails a timing check. A reset in the middle of the low phase must force the strobes high at the next edge, and the next write must still come out with correct timing.

// File: rtl/par_write_master.sv
module par_write_master #(
  parameter int CLK_PS      = 5000,
  parameter int T_CYCLE_NS  = 300,
  parameter int T_WRL_NS    = 60,
  parameter int T_WRH_NS    = 60,
  parameter int T_DSU_NS    = 40,
  parameter int T_DHO_NS    = 20,
  parameter int T_ASU_NS    = 10,
  parameter int T_CSH_NS    = 20
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  output logic       in_ready,
  input  logic [7:0] in_byte,
  input  logic       in_is_data,
  output logic       bus_sel_n,
  output logic       bus_dc,
  output logic       bus_wr_n,
  output logic       bus_rd_n,
  output logic [7:0] bus_d
);

  localparam int CYC_C = (T_CYCLE_NS * 1000 + CLK_PS - 1) / CLK_PS;
  localparam int WRL_C = (T_WRL_NS * 1000 + CLK_PS - 1) / CLK_PS;
  localparam int WRH_C = (T_WRH_NS * 1000 + CLK_PS - 1) / CLK_PS;
  localparam int DSU_C = (T_DSU_NS * 1000 + CLK_PS - 1) / CLK_PS;
  localparam int DHO_C = (T_DHO_NS * 1000 + CLK_PS - 1) / CLK_PS;
  localparam int ASU_C = (T_ASU_NS * 1000 + CLK_PS - 1) / CLK_PS;
  localparam int CSH_C = (T_CSH_NS * 1000 + CLK_PS - 1) / CLK_PS;

  localparam int S_C  = ASU_C;
  localparam int L0   = (WRL_C > DSU_C - S_C) ? WRL_C : DSU_C - S_C;
  localparam int L_C  = (L0 < 1) ? 1 : L0;
  localparam int H0   = (DHO_C > CSH_C) ? DHO_C : CSH_C;
  localparam int H_C  = (H0 < 1) ? 1 : H0;
  localparam int HI_C = (WRH_C < 1) ? 1 : WRH_C;
  localparam int T0   = (CYC_C > S_C + L_C + H_C) ? CYC_C : S_C + L_C + H_C;
  localparam int T_C  = (T0 > L_C + HI_C) ? T0 : L_C + HI_C;
  localparam int PW   = $clog2(T_C + 1);

  localparam logic [PW-1:0] PH_LO  = PW'(S_C);
  localparam logic [PW-1:0] PH_HI  = PW'(S_C + L_C);
  localparam logic [PW-1:0] PH_END = PW'(T_C - 1);

  logic          busy, busy_nx;
  logic [PW-1:0] ph, ph_nx;
  logic          take;

  assign in_ready = !busy || (ph == PH_END);
  assign take     = in_valid && in_ready;
  assign bus_rd_n = 1'b1;

  always_comb begin
    busy_nx = busy;
    ph_nx   = ph;
    if (take) begin
      busy_nx = 1'b1;
      ph_nx   = '0;
    end else if (busy && ph == PH_END) begin
      busy_nx = 1'b0;
      ph_nx   = '0;
    end else if (busy) begin
      ph_nx = ph + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      ph        <= '0;
      bus_sel_n <= 1'b1;
      bus_wr_n  <= 1'b1;
      bus_dc    <= 1'b1;
      bus_d     <= '0;
    end else begin
      busy      <= busy_nx;
      ph        <= ph_nx;
      bus_sel_n <= !busy_nx;
      bus_wr_n  <= !(busy_nx && ph_nx >= PH_LO && ph_nx < PH_HI);
      if (take) begin
        bus_d  <= in_byte;
        bus_dc <= in_is_data;
      end
    end
  end

  a_r1_reset_idle: assert property (@(posedge clk)
    !rst_n |=> bus_wr_n && bus_sel_n && bus_rd_n);

  a_r3_wr_under_cs: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_wr_n |-> !bus_sel_n);

  a_r4_low_phase_min: assert property (@(posedge clk) disable iff (!rst_n)
    (L_C > 1) && $fell(bus_wr_n) |=> !bus_wr_n);

  a_r5_bus_stable_low: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_wr_n && $past(!bus_wr_n) |-> $stable(bus_d) && $stable(bus_dc));

  a_r6_cs_after_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_wr_n) |-> !bus_sel_n);

  a_r7_no_take_while_low: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_wr_n |-> !in_ready);

endmodule

// File: tb/test_par_write_master.sv
module test_par_write_master;
  localparam int CLK_PS = 5000;
  localparam int CYC_C = (300 * 1000 + CLK_PS - 1) / CLK_PS;
  localparam int WRL_C = (60 * 1000 + CLK_PS - 1) / CLK_PS;
  localparam int WRH_C = (60 * 1000 + CLK_PS - 1) / CLK_PS;
  localparam int DSU_C = (40 * 1000 + CLK_PS - 1) / CLK_PS;
  localparam int DHO_C = (20 * 1000 + CLK_PS - 1) / CLK_PS;
  localparam int ASU_C = (10 * 1000 + CLK_PS - 1) / CLK_PS;
  localparam int CSH_C = (20 * 1000 + CLK_PS - 1) / CLK_PS;
  localparam int S_C  = ASU_C;
  localparam int L_C  = (WRL_C > DSU_C - S_C) ? WRL_C : DSU_C - S_C;
  localparam int H_C  = (DHO_C > CSH_C) ? DHO_C : CSH_C;
  localparam int T0   = (CYC_C > S_C + L_C + H_C) ? CYC_C : S_C + L_C + H_C;
  localparam int T_C  = (T0 > L_C + WRH_C) ? T0 : L_C + WRH_C;
  localparam int NONE = -1000000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [7:0] in_byte = 8'h00;
  logic in_is_data = 1'b0;
  logic bus_sel_n, bus_dc, bus_wr_n, bus_rd_n;
  logic [7:0] bus_d;

  par_write_master #(.CLK_PS(CLK_PS)) i_par_write_master (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_byte(in_byte), .in_is_data(in_is_data), .bus_sel_n(bus_sel_n),
    .bus_dc(bus_dc), .bus_wr_n(bus_wr_n), .bus_rd_n(bus_rd_n), .bus_d(bus_d)
  );

  always #2.5 clk = ~clk;

  typedef struct { logic [7:0] b; logic dc; int acc; } item_t;
  item_t q[$];

  int checks = 0, fails = 0, cyc = 0;
  int last_acc = NONE, prev_acc = NONE;
  int last_fall = NONE, last_rise = NONE, last_d_chg = NONE, last_dc_chg = NONE;
  bit rise_seen = 0;
  int writes_seen = 0, cs_hi_cnt = 0;
  logic p_wr = 1'b1, p_cs = 1'b1, p_dc = 1'b1;
  logic [7:0] p_d = 8'h00;
  bit done = 0;

  function automatic void chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", req, what, act, exp, cyc);
    end
  endfunction

  function automatic bit inwin(int acc, int lo, int hi);
    int d;
    d = cyc - acc;
    return (acc != NONE) && d >= lo && d <= hi;
  endfunction

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (!rst_n) begin
      p_wr = bus_wr_n; p_cs = bus_sel_n; p_d = bus_d; p_dc = bus_dc;
    end else begin
      chk(bus_rd_n == 1'b1, "R2", "read strobe", int'(bus_rd_n), 1);
      chk(bus_sel_n == !(inwin(last_acc, 0, T_C-1) || inwin(prev_acc, 0, T_C-1)),
          "R9", "chip select level", int'(bus_sel_n),
          int'(!(inwin(last_acc, 0, T_C-1) || inwin(prev_acc, 0, T_C-1))));
      chk(in_ready == !(inwin(last_acc, 0, T_C-2) || inwin(prev_acc, 0, T_C-2)),
          "R7", "ready level", int'(in_ready),
          int'(!(inwin(last_acc, 0, T_C-2) || inwin(prev_acc, 0, T_C-2))));
      if (bus_sel_n) cs_hi_cnt++;
      if (bus_d != p_d || bus_dc != p_dc) begin
        if (rise_seen)
          chk(cyc - last_rise >= DHO_C, "R5", "data hold after rise", cyc - last_rise, DHO_C);
        if (bus_d != p_d) last_d_chg = cyc;
        if (bus_dc != p_dc) last_dc_chg = cyc;
      end
      if (!p_cs && bus_sel_n && rise_seen)
        chk(cyc - last_rise >= CSH_C, "R6", "select hold after rise", cyc - last_rise, CSH_C);
      if (p_wr && !bus_wr_n) begin
        chk(q.size() > 0, "R3", "strobe fall with no pending byte", q.size(), 1);
        if (q.size() > 0)
          chk(cyc == q[0].acc + S_C, "R4", "fall offset", cyc - q[0].acc, S_C);
        chk(cyc - last_dc_chg >= S_C, "R5", "d/c setup before fall", cyc - last_dc_chg, S_C);
        if (rise_seen) begin
          chk(cyc - last_fall >= CYC_C, "R7", "fall to fall", cyc - last_fall, CYC_C);
          chk(cyc - last_rise >= WRH_C, "R7", "strobe high time", cyc - last_rise, WRH_C);
        end
        last_fall = cyc;
      end
      if (!p_wr && bus_wr_n) begin
        if (q.size() == 0) begin
          chk(0, "R3", "strobe rise with no pending byte", 0, 1);
        end else begin
          item_t it;
          it = q.pop_front();
          chk(bus_d == it.b, "R3", "latched byte", int'(bus_d), int'(it.b));
          chk(bus_dc == it.dc, "R3", "latched d/c", int'(bus_dc), int'(it.dc));
          chk(cyc == it.acc + S_C + L_C, "R4", "rise offset", cyc - it.acc, S_C + L_C);
        end
        chk(!bus_sel_n, "R3", "select low at rise", int'(bus_sel_n), 0);
        chk(cyc - last_fall >= WRL_C, "R4", "strobe low time", cyc - last_fall, WRL_C);
        chk(cyc - last_d_chg >= DSU_C, "R5", "data setup", cyc - last_d_chg, DSU_C);
        last_rise = cyc;
        rise_seen = 1;
        writes_seen++;
      end
      p_wr = bus_wr_n; p_cs = bus_sel_n; p_d = bus_d; p_dc = bus_dc;
    end
  end

  task automatic send(input logic [7:0] b, input logic dc, input bit keep);
    item_t it;
    in_valid = 1'b1; in_byte = b; in_is_data = dc;
    while (!in_ready) begin @(posedge clk); #1; end
    prev_acc = last_acc;
    last_acc = cyc + 1;
    it.b = b; it.dc = dc; it.acc = cyc + 1;
    q.push_back(it);
    @(posedge clk); #1;
    if (!keep) in_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic scramble(input int n);
    in_valid = 1'b0;
    for (int k = 0; k < n; k++) begin
      in_byte = 8'(k * 37 + 11);
      in_is_data = k[0];
      @(posedge clk); #1;
    end
  endtask

  initial begin
    int snap;
    idle(5);
    chk(bus_wr_n == 1'b1, "R1", "strobe in reset", int'(bus_wr_n), 1);
    chk(bus_sel_n == 1'b1, "R1", "select in reset", int'(bus_sel_n), 1);
    chk(bus_rd_n == 1'b1, "R1", "read strobe in reset", int'(bus_rd_n), 1);
    rst_n = 1'b1;
    idle(2);
    chk(in_ready == 1'b1, "R1", "ready after reset", int'(in_ready), 1);

    send(8'hA5, 1'b1, 0);
    idle(T_C + 10);
    send(8'h3C, 1'b0, 0);
    scramble(T_C + 20);

    send(8'h00, 1'b1, 1);
    snap = cs_hi_cnt;
    send(8'hFF, 1'b0, 1);
    send(8'h5A, 1'b1, 1);
    send(8'h81, 1'b0, 0);
    idle(T_C - 3);
    chk(cs_hi_cnt == snap, "R8", "select high cycles inside burst", cs_hi_cnt - snap, 0);
    idle(20);

    send(8'h77, 1'b1, 0);
    idle(S_C + 3);
    rst_n = 1'b0;
    @(posedge clk); #1;
    chk(bus_wr_n == 1'b1, "R1", "strobe after mid-cycle reset", int'(bus_wr_n), 1);
    chk(bus_sel_n == 1'b1, "R1", "select after mid-cycle reset", int'(bus_sel_n), 1);
    q.delete();
    last_acc = NONE; prev_acc = NONE; rise_seen = 0; last_fall = NONE;
    idle(2);
    rst_n = 1'b1;
    idle(2);
    chk(in_ready == 1'b1, "R1", "ready after mid-cycle reset", int'(in_ready), 1);
    send(8'hC3, 1'b0, 0);
    scramble(T_C + 10);

    chk(q.size() == 0, "R3", "bytes left unwritten", q.size(), 0);
    chk(writes_seen == 7, "R10", "strobe count", writes_seen, 7);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run did not finish, actual %0d expected 0 cycles left", 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule